// File: doc/BRIEF.md
# Two-Channel Fractional Baud Tick Divider

This block turns a fast system clock into two streams of one-cycle tick strobes whose average spacing need not be a whole number of input clocks. Each channel divides by an integer base and adds a correction fraction counted in sixteenths of a clock. A 4-bit phase accumulator decides which periods are one clock longer, so that over any sixteen consecutive ticks the total length is exactly sixteen times the base plus the fraction.

The infrared channel produces a sample tick whose base is the programmed count plus one, in single clocks. The UART channel produces a bit-rate tick whose base is built from groups of sixteen clocks, matching sixteen-times oversampling. Software sets each channel through two 16-bit register writes, one for the fraction and one for the count. Any write to a channel restarts that channel from a clean phase. A per-channel enable gates the tick.

Top module: `dual_baud_divider`

## Requirements
- R1: While reset is held and after its release with both enables low, neither tick output is ever high.
- R2: Write select 2'b01 loads the infrared count from data bits [3:0], all other bits ignored; with a zero fraction every infrared tick period is exactly count+1 clocks.
- R3: Write select 2'b00 loads the infrared fraction from data bits [7:4], other bits ignored; the span of any sixteen consecutive infrared periods is 16*(count+1)+fraction clocks.
- R4: Each single period of either channel is its base or its base plus one clock, never anything else.
- R5: An infrared count of zero is invalid: the infrared tick stays low for as long as that count is held.
- R6: Write select 2'b11 loads the UART count from data bits [7:0] and select 2'b10 loads the UART fraction from bits [7:4]; the UART base is (count+1)*16 clocks and sixteen consecutive UART periods span 16*base+fraction clocks.
- R7: A write to either register of a channel restarts that channel: counting the write cycle as cycle 0, the first tick is high in cycle base, with no stretch.
- R8: With its enable low a channel's tick is held low; counting the first cycle with the enable high again as cycle 1, the first tick is high in cycle base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_en | input | 1 | Infrared channel enable |
| uart_en | input | 1 | UART channel enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 00 IR fraction, 01 IR count, 10 UART fraction, 11 UART count |
| wr_data | input | 16 | Register write data |
| ir_tick | output | 1 | Infrared sample tick, one cycle wide |
| uart_tick | output | 1 | UART bit-rate tick, one cycle wide |

## Verification
A register write is sampled at one clock edge and the channel counter is zero in the next cycle, so the first tick is due in cycle base counting the write cycle as zero; enable behaves the same with the first enabled cycle as cycle one. The bench drives on falling edges and counts falling edges from the stimulus until the tick, comparing that count with the base. Period checks count falling edges between consecutive ticks, and the fractional checks sum sixteen of them against sixteen times the base plus the fraction, which holds for any window because the accumulator carries exactly fraction times per sixteen additions.

// File: rtl/baud_div_pkg.sv
// Package: shared constants and the register select encoding for the
// two-channel fractional tick divider.
package baud_div_pkg;
    localparam int FRAC_W   = 4;   // fraction width, sixteenths of a clock
    localparam int FRAC_LSB = 4;   // fraction field position in write data
    localparam int DATA_W   = 16;  // register write width

    typedef enum logic [1:0] {
        SEL_IR_FRAC = 2'b00,
        SEL_IR_CNT  = 2'b01,
        SEL_UA_FRAC = 2'b10,
        SEL_UA_CNT  = 2'b11
    } reg_sel_e;
endpackage

// File: rtl/baud_reg_bank.sv
// Module: baud_reg_bank
// Holds the fraction and count fields for both channels and raises a
// one-cycle restart pulse for the channel being written.
// Assumes: select bit 1 picks the channel, bit 0 picks count vs fraction.
module baud_reg_bank
    import baud_div_pkg::*;
#(
    parameter int IR_CNT_W = 4,
    parameter int UA_CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_sel_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    output logic [FRAC_W-1:0]   ir_frac_o,
    output logic [IR_CNT_W-1:0] ir_cnt_o,
    output logic [FRAC_W-1:0]   ua_frac_o,
    output logic [UA_CNT_W-1:0] ua_cnt_o,
    output logic                ir_clr_o,
    output logic                ua_clr_o
);
    reg_sel_e sel;
    logic     unused_hi_bits;

    assign sel            = reg_sel_e'(wr_sel_i);
    assign unused_hi_bits = ^wr_data_i[DATA_W-1:8];

    // Restart pulses: any write to a channel restarts that channel.
    assign ir_clr_o = wr_en_i && !wr_sel_i[1];
    assign ua_clr_o = wr_en_i &&  wr_sel_i[1];

    // Field capture: only the documented bits of each write are kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_frac_o <= '0;
            ir_cnt_o  <= '0;
            ua_frac_o <= '0;
            ua_cnt_o  <= '0;
        end else if (wr_en_i) begin
            case (sel)
                SEL_IR_FRAC: ir_frac_o <= wr_data_i[FRAC_LSB +: FRAC_W];
                SEL_IR_CNT:  ir_cnt_o  <= wr_data_i[IR_CNT_W-1:0];
                SEL_UA_FRAC: ua_frac_o <= wr_data_i[FRAC_LSB +: FRAC_W];
                default:     ua_cnt_o  <= wr_data_i[UA_CNT_W-1:0];
            endcase
        end
    end

    // R7: a single write never restarts both channels
    one_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ir_clr_o, ua_clr_o}));

    // R7: the written fraction is visible one cycle after its write
    frac_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 2'b00) |=> ir_frac_o == $past(wr_data_i[7:4]));
endmodule

// File: rtl/frac_tick_gen.sv
// Module: frac_tick_gen
// One divider channel. Base period is (count+1)*GROUP clocks; a FRAC_W-bit
// accumulator adds the fraction on every tick and its carry stretches the
// following period by one clock.
// Assumes: count and fraction only change together with clr_i.
module frac_tick_gen #(
    parameter int CNT_W      = 4,
    parameter int GROUP      = 1,
    parameter int FRAC_W     = 4,
    parameter bit ALLOW_ZERO = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              clr_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              tick_o
);
    localparam int PER_W = CNT_W + $clog2(GROUP) + 2;

    logic [PER_W-1:0]  base;
    logic [PER_W-1:0]  last;
    logic [PER_W-1:0]  cnt_q;
    logic [FRAC_W-1:0] acc_q;
    logic              stretch_q;
    logic              valid;
    logic              run;
    logic              at_end;

    // Legal-count decode: the variant is picked by ALLOW_ZERO.
    generate
        if (ALLOW_ZERO) begin : g_any_count
            assign valid = 1'b1;
        end else begin : g_nonzero_count
            assign valid = |count_i;
        end
    endgenerate

    assign base   = (PER_W'(count_i) + PER_W'(1)) * PER_W'(GROUP);
    assign last   = base + PER_W'(stretch_q) - PER_W'(1);
    assign run    = en_i && valid;
    assign at_end = run && (cnt_q == last);
    assign tick_o = at_end;

    // Period counter and fractional phase, restarted on clear or idle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || !run) begin
            cnt_q     <= '0;
            acc_q     <= '0;
            stretch_q <= 1'b0;
        end else if (at_end) begin
            cnt_q              <= '0;
            {stretch_q, acc_q} <= {1'b0, acc_q} + {1'b0, frac_i};
        end else begin
            cnt_q <= cnt_q + PER_W'(1);
        end
    end

    // Checker state: clocks since the previous tick of an unbroken run.
    logic [PER_W-1:0] gap_q;
    logic             seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || !run) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (tick_o) begin
            gap_q  <= PER_W'(1);
            seen_q <= 1'b1;
        end else begin
            gap_q <= gap_q + PER_W'(1);
        end
    end

    // R4
    period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && seen_q) |-> (gap_q == base || gap_q == base + PER_W'(1)));

    // R3
    no_stretch_zero_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frac_i == '0) |-> !stretch_q);

    // R8
    idle_phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (acc_q == '0 && !stretch_q));

    // R7
    restart_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0 && acc_q == '0));
endmodule

// File: rtl/dual_baud_divider.sv
// Module: dual_baud_divider
// Top: register bank plus an infrared channel (single-clock groups, zero
// count illegal) and a UART channel (sixteen-clock groups).
// Assumes: one register write per cycle at most.
module dual_baud_divider
    import baud_div_pkg::*;
#(
    parameter int IR_CNT_W  = 4,
    parameter int UA_CNT_W  = 8,
    parameter int UA_GROUP  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ir_en,
    input  logic        uart_en,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [15:0] wr_data,
    output logic        ir_tick,
    output logic        uart_tick
);
    logic [FRAC_W-1:0]   ir_frac;
    logic [IR_CNT_W-1:0] ir_cnt;
    logic [FRAC_W-1:0]   ua_frac;
    logic [UA_CNT_W-1:0] ua_cnt;
    logic                ir_clr;
    logic                ua_clr;

    baud_reg_bank #(
        .IR_CNT_W (IR_CNT_W),
        .UA_CNT_W (UA_CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .ir_frac_o (ir_frac),
        .ir_cnt_o  (ir_cnt),
        .ua_frac_o (ua_frac),
        .ua_cnt_o  (ua_cnt),
        .ir_clr_o  (ir_clr),
        .ua_clr_o  (ua_clr)
    );

    frac_tick_gen #(
        .CNT_W      (IR_CNT_W),
        .GROUP      (1),
        .FRAC_W     (FRAC_W),
        .ALLOW_ZERO (1'b0)
    ) u_ir_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (ir_en),
        .clr_i   (ir_clr),
        .count_i (ir_cnt),
        .frac_i  (ir_frac),
        .tick_o  (ir_tick)
    );

    frac_tick_gen #(
        .CNT_W      (UA_CNT_W),
        .GROUP      (UA_GROUP),
        .FRAC_W     (FRAC_W),
        .ALLOW_ZERO (1'b1)
    ) u_ua_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (uart_en),
        .clr_i   (ua_clr),
        .count_i (ua_cnt),
        .frac_i  (ua_frac),
        .tick_o  (uart_tick)
    );

    // R5
    ir_zero_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_cnt == '0) |-> !ir_tick);

    // R8
    ua_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uart_en |-> !uart_tick);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!ir_tick && !uart_tick));
endmodule

// File: tb/dual_baud_divider_bench.sv
module dual_baud_divider_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_en = 1'b0;
    logic        uart_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'b00;
    logic [15:0] wr_data = 16'h0;
    logic        ir_tick;
    logic        uart_tick;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dual_baud_divider u_dual_baud_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .ir_en     (ir_en),
        .uart_en   (uart_en),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .ir_tick   (ir_tick),
        .uart_tick (uart_tick)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic tick_of(input bit uart);
        return uart ? uart_tick : ir_tick;
    endfunction

    // Register write: write cycle is cycle 0, returns in cycle 1 (at negedge).
    task automatic write_reg(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 16'h0;
    endtask

    // Counts cycles from the current one (as 1) until a tick is seen.
    task automatic wait_tick(input bit uart, output int n);
        n = 1;
        while (!tick_of(uart) && n < 8000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic next_period(input bit uart, output int n);
        @(negedge clk);
        wait_tick(uart, n);
    endtask

    task automatic t_reset;
        int hits = 0;
        repeat (4) begin
            @(negedge clk);
            if (ir_tick || uart_tick) hits++;
        end
        check("R1 ticks during reset", hits, 0);
        rst_n = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (ir_tick || uart_tick) hits++;
        end
        check("R1 ticks after reset with enables low", hits, 0);
    endtask

    task automatic t_ir_integer;
        int n;
        int bad = 0;
        ir_en = 1'b1;
        write_reg(2'b00, 16'hF00F);          // fraction 0, junk elsewhere
        write_reg(2'b01, 16'hABC3);          // count 3 -> base 4
        wait_tick(1'b0, n);
        check("R7 IR first tick after count write", n, 4);
        for (int i = 0; i < 10; i++) begin
            next_period(1'b0, n);
            if (n != 4) bad++;
        end
        check("R2 IR integer periods all 4", bad, 0);
        write_reg(2'b01, 16'h7F09);          // count 9 -> base 10
        wait_tick(1'b0, n);
        check("R7 IR first tick base 10", n, 10);
        next_period(1'b0, n);
        check("R2 IR period base 10", n, 10);
    endtask

    task automatic avg_span(input bit uart, input int base, input int frac,
                            input string req);
        int n;
        int sum = 0;
        int odd = 0;
        wait_tick(uart, n);
        for (int i = 0; i < 16; i++) begin
            next_period(uart, n);
            sum += n;
            if (n != base && n != base + 1) odd++;
        end
        check(req, sum, 16 * base + frac);
        check("R4 single period base or base+1", odd, 0);
    endtask

    task automatic t_ir_fraction;
        int fr[3] = '{1, 8, 15};
        write_reg(2'b01, 16'h0003);          // base 4
        foreach (fr[k]) begin
            write_reg(2'b00, 16'hF00F | 16'(fr[k] << 4));
            avg_span(1'b0, 4, fr[k], "R3 IR sixteen-period span");
        end
    endtask

    task automatic t_ir_zero;
        int hits = 0;
        write_reg(2'b01, 16'hFFF0);          // count field 0: invalid
        repeat (100) begin
            @(negedge clk);
            if (ir_tick) hits++;
        end
        check("R5 IR zero count silent", hits, 0);
        write_reg(2'b00, 16'h0000);
        write_reg(2'b01, 16'h0001);          // base 2
        ir_en = 1'b0;
    endtask

    task automatic t_uart;
        int n;
        uart_en = 1'b1;
        write_reg(2'b10, 16'h0F50);          // fraction 5
        write_reg(2'b11, 16'h0102);          // count 2 -> base 48
        wait_tick(1'b1, n);
        check("R7 UART first tick after count write", n, 48);
        avg_span(1'b1, 48, 5, "R6 UART sixteen-period span");
        write_reg(2'b10, 16'h00C0);          // fraction 12, restarts
        wait_tick(1'b1, n);
        check("R7 UART first tick after fraction write", n, 48);
        avg_span(1'b1, 48, 12, "R6 UART span fraction 12");
    endtask

    task automatic t_enable;
        int n;
        int hits = 0;
        write_reg(2'b11, 16'h0000);          // base 16
        @(negedge clk);
        uart_en = 1'b0;
        repeat (60) begin
            @(negedge clk);
            if (uart_tick) hits++;
        end
        check("R8 UART tick low while disabled", hits, 0);
        uart_en = 1'b1;                      // this cycle is cycle 1
        wait_tick(1'b1, n);
        check("R8 UART first tick after enable", n, 16);
    endtask

    initial begin
        t_reset();
        t_ir_integer();
        t_ir_fraction();
        t_ir_zero();
        t_uart();
        t_enable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule